// File: doc/BRIEF.md
# Quarter-Rate Quadrature Down Converter

This block turns a stream of real signed 16-bit samples into a complex stream by mixing it with a local oscillator that runs at one quarter of the sample rate. At that rate every oscillator value is 1, 0 or -1. Each product is therefore the sample, zero, or the sample negated, and the block needs no multiplier. The real product leaves on the upper leg and the imaginary product on the lower leg. Each leg has its own valid strobe. Filtering and decimation are left to the stages that follow.

A sideband input picks the direction of the shift. When it is high, the shift is -fs/4 and the upper sideband lands on DC. When it is low, the shift is +fs/4 and the lower sideband lands on DC. A sync pulse puts the oscillator back at zero phase. Mixing takes place only when the 2-bit mode input holds the down-convert code. For any other mode code, both legs carry the input sample unchanged.

Top module: `quad_downmix`

## Requirements
- R1: Each output leg is registered once. A sample accepted with valid_i high appears on re_o and im_o one clock later, with re_valid_o and im_valid_o high for exactly that cycle.
- R2: When mode_i is not 2'b10, re_o and im_o both equal the accepted sample unchanged.
- R3: When mode_i is 2'b10, a 2-bit phase p advances by one for each accepted sample. re_o is x, 0, -x, 0 for p = 0, 1, 2, 3.
- R4: When mode_i is 2'b10 and upper_sb_i is 1 (shift -fs/4), im_o is 0, -x, 0, x for p = 0, 1, 2, 3.
- R5: When mode_i is 2'b10 and upper_sb_i is 0 (shift +fs/4), im_o is 0, x, 0, -x for p = 0, 1, 2, 3.
- R6: A sample accepted with sync_i high is mixed at p = 0, and the next sample uses p = 1. If sync_i is high in a cycle with no sample, the next accepted sample uses p = 0.
- R7: Negating -32768 gives +32767. No leg output ever wraps.
- R8: In cycles with valid_i low, the phase does not advance. re_o and im_o then hold their values and both valids are low.
- R9: During reset and after it, re_o and im_o are 0, both valids are low, and the phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 16 | Real input sample, two's complement |
| valid_i | input | 1 | Sample strobe |
| upper_sb_i | input | 1 | 1: -fs/4 shift; 0: +fs/4 shift |
| sync_i | input | 1 | Force oscillator zero phase |
| mode_i | input | 2 | 2'b10 enables mixing; other codes pass data through |
| re_o | output | 16 | Upper leg (real product) |
| re_valid_o | output | 1 | Upper leg valid |
| im_o | output | 16 | Lower leg (imaginary product) |
| im_valid_o | output | 1 | Lower leg valid |

## Verification
If the phase counter is out of step, a zero shows up on the wrong leg on the very next mixed sample, and the sign pattern becomes misaligned. The directed runs therefore first force phase zero with sync and then check every phase position. A sideband mistake turns the sign on im_o at phases 1 and 3. A missing saturation case gives -32768 where +32767 is expected, in the cycle right after the extreme sample. A phase that steps on idle cycles only becomes visible on the next accepted sample. For that reason, every gap test is followed by a mixed sample whose phase is known.

// File: rtl/qdm_pkg.sv
package qdm_pkg;
  typedef enum logic [1:0] {
    LO_ZERO = 2'd0,
    LO_POS  = 2'd1,
    LO_NEG  = 2'd2
  } lo_e;

  localparam logic [1:0] MODE_DNCONV = 2'b10;
  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/qdm_phase_gen.sv
module qdm_phase_gen
  import qdm_pkg::*;
#(
  parameter int unsigned PW = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic sync_i,
  input  logic upper_sb_i,
  output lo_e  cos_o,
  output lo_e  sin_o
);
  localparam logic [PW-1:0] PH_ZERO = '0;

  logic [PW-1:0] ph_q, ph_eff;

  // sync applies to the sample in the same cycle
  assign ph_eff = sync_i ? PH_ZERO : ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= PH_ZERO;
    else if (adv_i)  ph_q <= ph_eff + 1'b1;
    else if (sync_i) ph_q <= PH_ZERO;
  end

  lo_e sin_raw;

  always_comb begin
    cos_o   = LO_ZERO;
    sin_raw = LO_ZERO;
    unique case (ph_eff[1:0])
      2'd0: cos_o   = LO_POS;
      2'd1: sin_raw = LO_POS;
      2'd2: cos_o   = LO_NEG;
      default: sin_raw = LO_NEG;
    endcase
  end

  // upper sideband: imaginary leg uses -sin
  always_comb begin
    sin_o = sin_raw;
    if (upper_sb_i) begin
      unique case (sin_raw)
        LO_POS:  sin_o = LO_NEG;
        LO_NEG:  sin_o = LO_POS;
        default: sin_o = LO_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/qdm_sign_unit.sv
module qdm_sign_unit
  import qdm_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] x_i,
  input  lo_e           lo_i,
  input  logic          bypass_i,
  output logic [DW-1:0] y_o
);
  localparam logic [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] neg;
  assign neg = (x_i == S_MIN) ? S_MAX : (~x_i + 1'b1);

  always_comb begin
    if (bypass_i) y_o = x_i;
    else begin
      unique case (lo_i)
        LO_POS:  y_o = x_i;
        LO_NEG:  y_o = neg;
        default: y_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/quad_downmix.sv
module quad_downmix
  import qdm_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] sample_i,
  input  logic          valid_i,
  input  logic          upper_sb_i,
  input  logic          sync_i,
  input  logic [1:0]    mode_i,
  output logic [DW-1:0] re_o,
  output logic          re_valid_o,
  output logic [DW-1:0] im_o,
  output logic          im_valid_o
);
  logic bypass;
  lo_e  lo      [NUM_LEGS];
  logic [DW-1:0] leg_d [NUM_LEGS];
  logic [DW-1:0] leg_q [NUM_LEGS];
  logic [NUM_LEGS-1:0] vld_q;

  assign bypass = (mode_i != MODE_DNCONV);

  qdm_phase_gen #(.PW(2)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (valid_i),
    .sync_i     (sync_i),
    .upper_sb_i (upper_sb_i),
    .cos_o      (lo[0]),
    .sin_o      (lo[1])
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    qdm_sign_unit #(.DW(DW)) u_sign (
      .x_i      (sample_i),
      .lo_i     (lo[g]),
      .bypass_i (bypass),
      .y_o      (leg_d[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        leg_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else begin
        vld_q[g] <= valid_i;
        if (valid_i) leg_q[g] <= leg_d[g];
      end
    end
  end

  assign re_o       = leg_q[0];
  assign im_o       = leg_q[1];
  assign re_valid_o = vld_q[0];
  assign im_valid_o = vld_q[1];
endmodule

// File: rtl/quad_downmix_chk.sv
module quad_downmix_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] sample_i,
  input logic          valid_i,
  input logic          sync_i,
  input logic [1:0]    mode_i,
  input logic [DW-1:0] re_o,
  input logic          re_valid_o,
  input logic [DW-1:0] im_o,
  input logic          im_valid_o
);
  localparam logic [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};

  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (re_valid_o && im_valid_o));

  assert_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i != 2'b10) |=> (re_o == $past(sample_i) && im_o == $past(sample_i)));

  assert_one_leg_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b10) |=> (re_o == '0 || im_o == '0));

  assert_sync_phase0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sync_i && mode_i == 2'b10) |=> (re_o == $past(sample_i) && im_o == '0));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b10 && sample_i != S_MIN) |=> (im_o != S_MIN));

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(re_o) && $stable(im_o) && !re_valid_o && !im_valid_o));
endmodule

bind quad_downmix quad_downmix_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sample_i   (sample_i),
  .valid_i    (valid_i),
  .sync_i     (sync_i),
  .mode_i     (mode_i),
  .re_o       (re_o),
  .re_valid_o (re_valid_o),
  .im_o       (im_o),
  .im_valid_o (im_valid_o)
);

// File: tb/quad_downmix_tb.sv
module quad_downmix_tb;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic          valid_i = 1'b0;
  logic          upper_sb_i = 1'b1;
  logic          sync_i = 1'b0;
  logic [1:0]    mode_i = 2'b10;
  logic [DW-1:0] re_o, im_o;
  logic          re_valid_o, im_valid_o;

  int n_chk = 0;
  int n_err = 0;
  int ph_m = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  quad_downmix #(.DW(DW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .valid_i(valid_i),
    .upper_sb_i(upper_sb_i), .sync_i(sync_i), .mode_i(mode_i),
    .re_o(re_o), .re_valid_o(re_valid_o), .im_o(im_o), .im_valid_o(im_valid_o)
  );

  function automatic logic [DW-1:0] sneg(logic [DW-1:0] x);
    return (x == 16'h8000) ? 16'h7fff : -x;
  endfunction

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one sample at negedge, check at the next negedge
  task automatic push(string req, logic [DW-1:0] x, bit sb, bit sy, logic [1:0] md);
    logic [DW-1:0] e_re, e_im;
    int p;
    p = sy ? 0 : ph_m;
    ph_m = (p + 1) % 4;
    if (md != 2'b10) begin
      e_re = x; e_im = x;
    end else begin
      e_re = (p == 0) ? x : (p == 2) ? sneg(x) : '0;
      if (p == 1)      e_im = sb ? sneg(x) : x;
      else if (p == 3) e_im = sb ? x : sneg(x);
      else             e_im = '0;
    end
    sample_i = x; upper_sb_i = sb; sync_i = sy; mode_i = md; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; sync_i = 1'b0;
    chk({req, " re"}, re_o, e_re);
    chk({req, " im"}, im_o, e_im);
    chk("R1 valids", {15'd0, re_valid_o & im_valid_o}, 16'd1);
  endtask

  task automatic t_reset;
    chk("R9 re", re_o, '0);
    chk("R9 im", im_o, '0);
    chk("R9 valids", {14'd0, re_valid_o, im_valid_o}, '0);
    ph_m = 0;
    push("R9 phase0", 16'h1234, 1'b1, 1'b0, 2'b10);
  endtask

  task automatic t_bypass;
    push("R2 mode00", 16'h0a0b, 1'b1, 1'b0, 2'b00);
    push("R2 mode01", 16'h8000, 1'b0, 1'b0, 2'b01);
    push("R2 mode11", 16'hfff3, 1'b1, 1'b1, 2'b11);
  endtask

  task automatic t_upper;
    push("R6 sync", 16'h0100, 1'b1, 1'b1, 2'b10);
    for (int i = 1; i < 8; i++)
      push("R3 R4 upper", 16'(i * 16'h0321 - 16'h0800), 1'b1, 1'b0, 2'b10);
  endtask

  task automatic t_lower;
    push("R6 sync", 16'h7000, 1'b0, 1'b1, 2'b10);
    for (int i = 1; i < 8; i++)
      push("R3 R5 lower", 16'(16'h0400 - i * 16'h0177), 1'b0, 1'b0, 2'b10);
  endtask

  task automatic t_sync_idle;
    push("R3", 16'h0050, 1'b1, 1'b0, 2'b10);
    sync_i = 1'b1;
    @(negedge clk_i);
    sync_i = 1'b0;
    ph_m = 0;
    push("R6 idle sync", 16'h0222, 1'b1, 1'b0, 2'b10);
    push("R6 after", 16'h0333, 1'b1, 1'b0, 2'b10);
  endtask

  task automatic t_gap;
    logic [DW-1:0] r0, i0;
    r0 = re_o; i0 = im_o;
    repeat (3) @(negedge clk_i);
    chk("R8 hold re", re_o, r0);
    chk("R8 hold im", im_o, i0);
    chk("R8 valids low", {14'd0, re_valid_o, im_valid_o}, '0);
    push("R8 phase kept", 16'h0444, 1'b0, 1'b0, 2'b10);
  endtask

  task automatic t_sat;
    push("R7 sync", 16'h8000, 1'b1, 1'b1, 2'b10);
    push("R7 im neg", 16'h8000, 1'b1, 1'b0, 2'b10);
    push("R7 re neg", 16'h8000, 1'b1, 1'b0, 2'b10);
    push("R7 lower im neg", 16'h8000, 1'b0, 1'b0, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset_pre: begin
      chk("R9 in reset", re_o | im_o, '0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_bypass();
    t_upper();
    t_lower();
    t_sync_idle();
    t_gap();
    t_sat();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule